// File: doc/BRIEF.md
# Priority Pin Crossbar Allocator

This block decides which peripheral signal drives each of 32 general-purpose pins. The pins form four ports of eight. Pin number `port*8 + bit` orders them from the lowest pin of port 0 to the highest pin of port 3. The block serves a fixed list of 22 peripheral signals, each with an enable. The UART pair always goes to two fixed pins. The allocator then takes every other enabled signal in priority order and gives it the lowest-numbered pin that is still free. A pin counts as occupied if an earlier signal already holds it or if its skip-mask bit is set. Software sets skip bits for pins that are kept for analog use, for dedicated functions or for plain GPIO.

The enables, the four-wire SPI select and the skip masks are captured in a register stage. A combinational walk computes the placement, and a second register stage holds the result. The block reports results two ways. Each pin has a valid bit and the index of the signal driving it. Each signal has a placed flag and the number of the pin it landed on. A pin that is not valid is left to GPIO.

Top module: `xbar_alloc`

## Requirements
- R1: A synchronous reset clears every pin valid bit, every placed flag and all index fields, and the outputs stay cleared from the first clock edge after reset.
- R2: When enabled, signal index 0 (UART transmit) is placed on pin 4 and signal index 1 (UART receive) on pin 5. This holds even when those pins have their skip bits set.
- R3: Pins taken by the enabled UART signals count as occupied for every later signal. A UART signal that is disabled leaves its pin free for the walk.
- R4: Signals with index 2 through 21 are visited in ascending index order, which is the priority order. The list is SPI clock, SPI in, SPI out, SPI select, I2C data, I2C clock, comparator 0 sync/async, comparator 1 sync/async, clock out, PWM 0 to 5, counter clock in, timer 0 in, timer 1 in. Each enabled signal takes the lowest pin that is neither skipped nor already assigned.
- R5: Skip-mask bit n covers pin n, so mask port 1 with value 0x03 covers pins 8 and 9. A pin whose skip bit is set is never given to a walked signal.
- R6: Signal index 5 (SPI select) takes a pin only when `spi_four_wire` is 1. Otherwise it consumes no pin and reports not placed.
- R7: An enabled signal that finds no free pin reports placed = 0 and a pin field of 0. Later signals are still walked.
- R8: For each placed signal, the pin it reports is valid and carries that signal's index. The number of valid pins equals the number of placed signals.
- R9: A change on the inputs appears on the outputs after two rising clock edges. After one edge the outputs still show the previous placement.
- R10: A disabled signal is never placed and drives no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| func_en | input | 22 | Per-signal enable, bit = signal index |
| spi_four_wire | input | 1 | SPI select line takes part in allocation |
| skip_mask | input | 32 | Skip bits, bit port*8+bit; port p is bits [8p+7:8p] |
| pin_valid | output | 32 | Pin n is driven by a peripheral signal |
| pin_func | output | 160 | Signal index driving pin n, bits [5n+4:5n] |
| func_placed | output | 22 | Signal k received a pin |
| func_pin | output | 110 | Pin number of signal k, bits [5k+4:5k] |

## Verification
Every placement is due at the negedge that follows the second rising edge after the inputs were driven. At the negedge after the first edge, the outputs must still show the previous pattern's placement. For each pattern it applies, the driver queues two entries, stamped with the cycle counts of those two sample points, and the monitor compares an entry only when the cycle counter reaches its stamp. Reset clearing is sampled one edge after reset is raised, with all inputs held at zero so the walk after release also starts from a cleared state.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    localparam int FUNC_COUNT = 22;
    localparam int FIDX_W     = $clog2(FUNC_COUNT);

    typedef enum logic [FIDX_W-1:0] {
        FN_UART_TX     = 5'd0,
        FN_UART_RX     = 5'd1,
        FN_SPI_CLK     = 5'd2,
        FN_SPI_MISO    = 5'd3,
        FN_SPI_MOSI    = 5'd4,
        FN_SPI_SEL     = 5'd5,
        FN_I2C_DATA    = 5'd6,
        FN_I2C_CLK     = 5'd7,
        FN_CMP0_SYNC   = 5'd8,
        FN_CMP0_ASYNC  = 5'd9,
        FN_CMP1_SYNC   = 5'd10,
        FN_CMP1_ASYNC  = 5'd11,
        FN_CLK_OUT     = 5'd12,
        FN_PWM0        = 5'd13,
        FN_PWM1        = 5'd14,
        FN_PWM2        = 5'd15,
        FN_PWM3        = 5'd16,
        FN_PWM4        = 5'd17,
        FN_PWM5        = 5'd18,
        FN_CNT_CLK_IN  = 5'd19,
        FN_TMR0_IN     = 5'd20,
        FN_TMR1_IN     = 5'd21
    } func_id_e;

    // First signal index handled by the priority walk (UART pair sits below).
    localparam int WALK_FIRST = 2;

endpackage

// File: rtl/xbar_req_stage.sv
module xbar_req_stage
    import xbar_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [FUNC_COUNT-1:0] en_d,
    input  logic                  four_d,
    input  logic [NPINS-1:0]      skip_d,
    output logic [FUNC_COUNT-1:0] en_q,
    output logic                  four_q,
    output logic [NPINS-1:0]      skip_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            four_q <= 1'b0;
            skip_q <= '0;
        end else begin
            en_q   <= en_d;
            four_q <= four_d;
            skip_q <= skip_d;
        end
    end

endmodule

// File: rtl/xbar_walk.sv
module xbar_walk
    import xbar_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int PW     = 5,
    parameter int TX_PIN = 4,
    parameter int RX_PIN = 5
) (
    input  logic [FUNC_COUNT-1:0]         en,
    input  logic                          four,
    input  logic [NPINS-1:0]              skip,
    output logic [FUNC_COUNT-1:0]         placed,
    output logic [FUNC_COUNT-1:0][PW-1:0] fn_pin
);

    always_comb begin
        logic [NPINS-1:0] occ;
        logic             want;
        logic             found;
        logic [PW-1:0]    sel;

        placed = '0;
        fn_pin = '0;
        occ    = skip;
        want   = 1'b0;
        found  = 1'b0;
        sel    = '0;

        // Fixed UART pins: placed regardless of skip, then marked occupied.
        if (en[FN_UART_TX]) begin
            placed[FN_UART_TX] = 1'b1;
            fn_pin[FN_UART_TX] = PW'(TX_PIN);
            occ[TX_PIN]        = 1'b1;
        end
        if (en[FN_UART_RX]) begin
            placed[FN_UART_RX] = 1'b1;
            fn_pin[FN_UART_RX] = PW'(RX_PIN);
            occ[RX_PIN]        = 1'b1;
        end

        // Priority walk: each request takes the lowest unoccupied pin.
        for (int f = WALK_FIRST; f < FUNC_COUNT; f++) begin
            want  = en[f] && ((f != int'(FN_SPI_SEL)) || four);
            found = 1'b0;
            sel   = '0;
            for (int p = 0; p < NPINS; p++) begin
                if (!found && !occ[p]) begin
                    found = 1'b1;
                    sel   = PW'(p);
                end
            end
            if (want && found) begin
                placed[f] = 1'b1;
                fn_pin[f] = sel;
                occ[sel]  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/xbar_pin_map.sv
module xbar_pin_map
    import xbar_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int PW    = 5
) (
    input  logic [FUNC_COUNT-1:0]         placed,
    input  logic [FUNC_COUNT-1:0][PW-1:0] fn_pin,
    output logic [NPINS-1:0]              pin_used,
    output logic [NPINS-1:0][FIDX_W-1:0]  pin_fn
);

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic              hit;
        logic [FIDX_W-1:0] idx;

        always_comb begin
            hit = 1'b0;
            idx = '0;
            for (int f = 0; f < FUNC_COUNT; f++) begin
                if (placed[f] && (fn_pin[f] == PW'(p))) begin
                    hit = 1'b1;
                    idx = FIDX_W'(f);
                end
            end
        end

        assign pin_used[p] = hit;
        assign pin_fn[p]   = idx;
    end

endmodule

// File: rtl/xbar_out_stage.sv
module xbar_out_stage
    import xbar_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int PW    = 5
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [FUNC_COUNT-1:0]         placed_d,
    input  logic [FUNC_COUNT-1:0][PW-1:0] fn_pin_d,
    input  logic [NPINS-1:0]              pin_used_d,
    input  logic [NPINS-1:0][FIDX_W-1:0]  pin_fn_d,
    output logic [FUNC_COUNT-1:0]         placed_q,
    output logic [FUNC_COUNT-1:0][PW-1:0] fn_pin_q,
    output logic [NPINS-1:0]              pin_used_q,
    output logic [NPINS-1:0][FIDX_W-1:0]  pin_fn_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            placed_q   <= '0;
            fn_pin_q   <= '0;
            pin_used_q <= '0;
            pin_fn_q   <= '0;
        end else begin
            placed_q   <= placed_d;
            fn_pin_q   <= fn_pin_d;
            pin_used_q <= pin_used_d;
            pin_fn_q   <= pin_fn_d;
        end
    end

endmodule

// File: rtl/xbar_alloc.sv
module xbar_alloc
    import xbar_pkg::*;
#(
    parameter int PORT_COUNT = 4,
    parameter int PORT_WIDTH = 8,
    parameter int TX_PIN     = 4,
    parameter int RX_PIN     = 5
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [FUNC_COUNT-1:0]                func_en,
    input  logic                                 spi_four_wire,
    input  logic [PORT_COUNT*PORT_WIDTH-1:0]     skip_mask,
    output logic [PORT_COUNT*PORT_WIDTH-1:0]     pin_valid,
    output logic [PORT_COUNT*PORT_WIDTH*FIDX_W-1:0] pin_func,
    output logic [FUNC_COUNT-1:0]                func_placed,
    output logic [FUNC_COUNT*$clog2(PORT_COUNT*PORT_WIDTH)-1:0] func_pin
);

    localparam int NPINS = PORT_COUNT * PORT_WIDTH;
    localparam int PW    = $clog2(NPINS);

    logic [FUNC_COUNT-1:0]         en_q;
    logic                          four_q;
    logic [NPINS-1:0]              skip_q;
    logic [FUNC_COUNT-1:0]         placed_c;
    logic [FUNC_COUNT-1:0][PW-1:0] fn_pin_c;
    logic [NPINS-1:0]              pin_used_c;
    logic [NPINS-1:0][FIDX_W-1:0]  pin_fn_c;
    logic [FUNC_COUNT-1:0][PW-1:0] fn_pin_q;
    logic [NPINS-1:0][FIDX_W-1:0]  pin_fn_q;

    xbar_req_stage #(.NPINS(NPINS)) u_req (
        .clk    (clk),
        .rst    (rst),
        .en_d   (func_en),
        .four_d (spi_four_wire),
        .skip_d (skip_mask),
        .en_q   (en_q),
        .four_q (four_q),
        .skip_q (skip_q)
    );

    xbar_walk #(.NPINS(NPINS), .PW(PW), .TX_PIN(TX_PIN), .RX_PIN(RX_PIN)) u_walk (
        .en     (en_q),
        .four   (four_q),
        .skip   (skip_q),
        .placed (placed_c),
        .fn_pin (fn_pin_c)
    );

    xbar_pin_map #(.NPINS(NPINS), .PW(PW)) u_map (
        .placed   (placed_c),
        .fn_pin   (fn_pin_c),
        .pin_used (pin_used_c),
        .pin_fn   (pin_fn_c)
    );

    xbar_out_stage #(.NPINS(NPINS), .PW(PW)) u_out (
        .clk        (clk),
        .rst        (rst),
        .placed_d   (placed_c),
        .fn_pin_d   (fn_pin_c),
        .pin_used_d (pin_used_c),
        .pin_fn_d   (pin_fn_c),
        .placed_q   (func_placed),
        .fn_pin_q   (fn_pin_q),
        .pin_used_q (pin_valid),
        .pin_fn_q   (pin_fn_q)
    );

    assign func_pin = fn_pin_q;
    assign pin_func = pin_fn_q;

endmodule

// File: rtl/xbar_alloc_chk.sv
module xbar_alloc_chk
    import xbar_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int PW     = 5,
    parameter int TX_PIN = 4,
    parameter int RX_PIN = 5
) (
    input logic                       clk,
    input logic                       rst,
    input logic [FUNC_COUNT-1:0]      en_q,
    input logic                       four_q,
    input logic [NPINS-1:0]           skip_q,
    input logic [NPINS-1:0]           pin_valid,
    input logic [NPINS*FIDX_W-1:0]    pin_func,
    input logic [FUNC_COUNT-1:0]      func_placed,
    input logic [FUNC_COUNT*PW-1:0]   func_pin
);

    localparam logic [NPINS-1:0] UART_PINS = (NPINS'(1) << TX_PIN) | (NPINS'(1) << RX_PIN);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (pin_valid == '0) && (func_placed == '0));

    p_uart_tx_fixed_r2: assert property (@(posedge clk) disable iff (rst)
        en_q[FN_UART_TX] |=> func_placed[FN_UART_TX]
                             && (func_pin[0 +: PW] == PW'(TX_PIN))
                             && pin_valid[TX_PIN]
                             && (pin_func[TX_PIN*FIDX_W +: FIDX_W] == FIDX_W'(FN_UART_TX)));

    p_uart_rx_fixed_r2: assert property (@(posedge clk) disable iff (rst)
        en_q[FN_UART_RX] |=> func_placed[FN_UART_RX]
                             && (func_pin[PW +: PW] == PW'(RX_PIN))
                             && pin_valid[RX_PIN]);

    p_skip_honoured_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pin_valid & $past(skip_q) & ~UART_PINS) == '0));

    p_sel_three_wire_r6: assert property (@(posedge clk) disable iff (rst)
        !four_q |=> !func_placed[FN_SPI_SEL]);

    p_count_match_r8: assert property (@(posedge clk) disable iff (rst)
        $countones(pin_valid) == $countones(func_placed));

    p_disabled_unplaced_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((func_placed & ~$past(en_q)) == '0));

endmodule

bind xbar_alloc xbar_alloc_chk #(
    .NPINS  (NPINS),
    .PW     (PW),
    .TX_PIN (TX_PIN),
    .RX_PIN (RX_PIN)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .en_q        (en_q),
    .four_q      (four_q),
    .skip_q      (skip_q),
    .pin_valid   (pin_valid),
    .pin_func    (pin_func),
    .func_placed (func_placed),
    .func_pin    (func_pin)
);

// File: tb/xbar_alloc_bench.sv
`timescale 1ns/1ps
module xbar_alloc_bench;
    import xbar_pkg::*;

    localparam int NP = 32;
    localparam int NF = FUNC_COUNT;
    localparam int FW = FIDX_W;
    localparam int PW = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NF-1:0]     func_en = '0;
    logic              spi_four_wire = 1'b0;
    logic [NP-1:0]     skip_mask = '0;
    logic [NP-1:0]     pin_valid;
    logic [NP*FW-1:0]  pin_func;
    logic [NF-1:0]     func_placed;
    logic [NF*PW-1:0]  func_pin;

    xbar_alloc u_xbar_alloc (
        .clk           (clk),
        .rst           (rst),
        .func_en       (func_en),
        .spi_four_wire (spi_four_wire),
        .skip_mask     (skip_mask),
        .pin_valid     (pin_valid),
        .pin_func      (pin_func),
        .func_placed   (func_placed),
        .func_pin      (func_pin)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int               due;
        string            tag;
        logic [NP-1:0]    pv;
        logic [NP*FW-1:0] pf;
        logic [NF-1:0]    fp;
        logic [NF*PW-1:0] fpin;
    } exp_t;

    exp_t sbq[$];
    exp_t prev_e;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    task automatic check(input string tag, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Behavioural walk of the priority list from the requirements.
    task automatic model(input logic [NF-1:0] en, input logic four,
                         input logic [NP-1:0] skip, output exp_t e);
        logic [NP-1:0] occ;
        int            pin;
        e.due = 0; e.tag = ""; e.pv = '0; e.pf = '0; e.fp = '0; e.fpin = '0;
        occ = skip;
        for (int f = 0; f < NF; f++) begin
            pin = -1;
            if (f < 2) begin
                if (en[f]) pin = (f == 0) ? 4 : 5;
            end else if (en[f] && (f != 5 || four)) begin
                for (int p = 0; p < NP; p++)
                    if (pin < 0 && !occ[p]) pin = p;
            end
            if (pin >= 0) begin
                occ[pin] = 1'b1;
                e.fp[f] = 1'b1;
                e.fpin[f*PW +: PW] = PW'(pin);
                e.pv[pin] = 1'b1;
                e.pf[pin*FW +: FW] = FW'(f);
            end
        end
    endtask

    task automatic zero_exp(output exp_t e);
        e.due = 0; e.tag = ""; e.pv = '0; e.pf = '0; e.fp = '0; e.fpin = '0;
    endtask

    // Driver: apply a pattern, queue the held-over and the new placement.
    task automatic drive(input logic [NF-1:0] en, input logic four,
                         input logic [NP-1:0] skip, input string tag);
        exp_t e, p;
        @(negedge clk);
        func_en = en; spi_four_wire = four; skip_mask = skip;
        model(en, four, skip, e);
        p = prev_e; p.due = cyc + 1; p.tag = "R9";
        e.due = cyc + 2; e.tag = tag;
        sbq.push_back(p);
        sbq.push_back(e);
        prev_e = e;
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
    endtask

    // Monitor
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            exp_t e;
            e = sbq.pop_front();
            check(e.tag, "pin_valid",   256'(pin_valid),   256'(e.pv));
            check(e.tag, "pin_func",    256'(pin_func),    256'(e.pf));
            check(e.tag, "func_placed", 256'(func_placed), 256'(e.fp));
            check(e.tag, "func_pin",    256'(func_pin),    256'(e.fpin));
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic do_reset();
        @(negedge clk);
        func_en = '0; spi_four_wire = 1'b0; skip_mask = '0;
        rst = 1'b1;
        @(negedge clk);
        check("R1", "pin_valid",   256'(pin_valid),   256'(0));
        check("R1", "func_placed", 256'(func_placed), 256'(0));
        check("R1", "func_pin",    256'(func_pin),    256'(0));
        rst = 1'b0;
        zero_exp(prev_e);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R9 watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    localparam logic [NF-1:0] ALL_EN = '1;
    localparam logic [NF-1:0] NO_UART = ALL_EN & ~NF'(3);

    initial begin
        zero_exp(prev_e);
        repeat (3) @(negedge clk);
        check("R1", "pin_valid after reset",   256'(pin_valid),   256'(0));
        check("R1", "func_placed after reset", 256'(func_placed), 256'(0));
        rst = 1'b0;

        // R4: lone SPI clock with no skips lands on pin 0
        drive(NF'(1) << FN_SPI_CLK, 1'b1, '0, "R4");
        drain();
        check("R4", "spi clk on pin 0", 256'(func_pin[2*PW +: PW]), 256'(0));
        // R4: lowest pin skipped, moves to pin 1
        drive(NF'(1) << FN_SPI_CLK, 1'b1, NP'(1), "R4");
        drain();
        check("R4", "spi clk on pin 1", 256'(func_pin[2*PW +: PW]), 256'(1));

        // R4/R3: everything enabled, no skips
        drive(ALL_EN, 1'b1, '0, "R4");
        // R5: port 1 mask 0x03
        drive(ALL_EN, 1'b1, NP'(32'h0000_0300), "R5");
        drain();
        check("R5", "pins 8 and 9 unused", 256'(pin_valid[9:8]), 256'(0));
        // R2: UART pins skipped, still placed on fixed pins
        drive(ALL_EN, 1'b1, NP'(32'h0000_0030), "R2");
        // R3: UART off frees pins 4 and 5
        drive(NO_UART, 1'b1, '0, "R3");
        drain();
        check("R3", "pin 4 goes to walked signal", 256'(pin_valid[4]), 256'(1));
        // R6: three-wire SPI
        drive(ALL_EN, 1'b0, '0, "R6");
        drain();
        check("R6", "select unplaced", 256'(func_placed[FN_SPI_SEL]), 256'(0));
        // R7: all pins skipped, only UART placed
        drive(ALL_EN, 1'b1, '1, "R7");
        // R7: only three pins left for the walk
        drive(ALL_EN, 1'b1, ~NP'(32'h8001_0002), "R7");
        drain();
        check("R7", "timer1 not placed", 256'(func_placed[FN_TMR1_IN]), 256'(0));
        check("R7", "timer1 pin field", 256'(func_pin[21*PW +: PW]), 256'(0));
        // R10: alternate enables
        drive(NF'(22'h2AAAAA), 1'b1, '0, "R10");
        drive(NF'(22'h155555), 1'b1, NP'(32'h00FF_0000), "R10");

        // R1: reset mid-run
        drain();
        do_reset();

        // R8/R4: random patterns applied back to back
        for (int i = 0; i < 300; i++) begin
            logic [NP-1:0] sk;
            case (i % 3)
                0: sk = NP'($urandom & $urandom & $urandom);
                1: sk = NP'($urandom & $urandom);
                default: sk = NP'($urandom | $urandom);
            endcase
            drive(NF'($urandom), 1'($urandom), sk, "R8");
        end
        drain();
        drain();

        done = 1'b1;
        summary();
        $finish;
    end

endmodule